// File: doc/BRIEF.md
# Invalidate Request Completion Tracker

This block lives on the processor side of a shared-memory system and follows a single cache-line invalidate that the cache controller raises when a store hits a line held in the shared state. It latches the line address, stalls the store by holding its request-ready low, and waits for the request to be closed. There are three ways to close it: a dedicated acknowledge input (success), a dedicated error input (failure, reported as a bus error against the stalled store), or a cancel from the external agent. A cancel only counts while the agent is presenting an external invalidate, update, snoop or intervention transaction.

Every close produces a one-cycle completion pulse and a one-cycle store-release pulse. The tracker then returns to idle and can take the next request. Acknowledge and error are sampled every cycle, whatever other bus traffic is in flight. A completion that arrives with nothing outstanding is dropped and recorded in a sticky violation flag. When the system is not configured for multiprocessing, request inputs are ignored.

Top module: `inv_req_tracker`

## Requirements
- R1: After reset, `req_ready`=1, `pending`=0, `done_ok`=`bus_err`=`cancelled`=`store_release`=0, `proto_viol`=0 and `line_addr`=0.
- R2: When `req_ready`=1, `mp_enable`=1 and `req_valid`=1 at a clock edge, from the next cycle `pending`=1, `req_ready`=0 and `line_addr` holds the `req_addr` that was sampled.
- R3: With `mp_enable`=0 a request is ignored: `pending` stays 0 and `req_ready` stays 1.
- R4: While `pending`=1, further requests are refused and `line_addr` does not change. With no close input present, `pending` stays 1.
- R5: An edge with `pending`=1 and `ack_in`=1 (and `err_in`=0) gives `done_ok`=1 and `store_release`=1 for exactly the next cycle. `req_ready`=1 in the cycle after that.
- R6: An edge with `pending`=1 and `err_in`=1 gives `bus_err`=1 and `store_release`=1 for exactly the next cycle. `line_addr` still shows the failed line during that cycle.
- R7: When `ack_in` and `err_in` are both 1 in the same cycle, the error wins: `bus_err` pulses and `done_ok` stays 0.
- R8: A cancel is recognised only when `cancel_in`=1, `ext_req_valid`=1 and `ext_req_kind` is 1 (invalidate), 2 (update), 3 (snoop) or 4 (intervention). It then gives `cancelled`=1 and `store_release`=1 for one cycle. Kinds 0 and 5 to 7, or `ext_req_valid`=0, leave the request pending.
- R9: Acknowledge and error outrank a recognised cancel that arrives in the same cycle.
- R10: An `ack_in` or `err_in` seen while idle is ignored (no completion pulse, still idle) and sets `proto_viol`. `proto_viol` stays set until reset.
- R11: At most one of `done_ok`, `bus_err` and `cancelled` is 1 in any cycle. Each completion is followed by idle, and a request offered during a completion cycle is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mp_enable | input | 1 | System configured for multiprocessing |
| req_valid | input | 1 | Invalidate request from cache controller |
| req_addr | input | LINE_W | Line address of the request |
| ack_in | input | 1 | Dedicated completion acknowledge |
| err_in | input | 1 | Dedicated completion error |
| cancel_in | input | 1 | Cancel strobe from external agent |
| ext_req_valid | input | 1 | External transaction present |
| ext_req_kind | input | 3 | External transaction kind (1 inv, 2 upd, 3 snoop, 4 interv) |
| req_ready | output | 1 | Tracker idle and able to take a request |
| pending | output | 1 | A request is outstanding |
| line_addr | output | LINE_W | Address of the tracked line |
| done_ok | output | 1 | One-cycle success pulse |
| bus_err | output | 1 | One-cycle bus error on the issuing store |
| cancelled | output | 1 | One-cycle cancellation pulse |
| store_release | output | 1 | One-cycle release of the stalled store |
| proto_viol | output | 1 | Sticky stray-completion flag |

## Verification
Each request is closed with a different mix of acknowledge, error, cancel strobe and external-transaction kind. The mixes include all four cancelling kinds, non-cancelling kinds, a cancel with no valid transaction, and completions that coincide with unrelated external traffic. This separates the three close paths and shows how they are ranked when they collide. Directed sequences then cover the disabled configuration, refused requests while pending and during a completion cycle, stray completions while idle, and the clearing of the sticky flag by reset.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam int KIND_W = 3;

    localparam logic [KIND_W-1:0] KIND_NONE   = 3'd0;
    localparam logic [KIND_W-1:0] KIND_INVAL  = 3'd1;
    localparam logic [KIND_W-1:0] KIND_UPDATE = 3'd2;
    localparam logic [KIND_W-1:0] KIND_SNOOP  = 3'd3;
    localparam logic [KIND_W-1:0] KIND_INTERV = 3'd4;
    localparam logic [KIND_W-1:0] KIND_READ   = 3'd5;
    localparam logic [KIND_W-1:0] KIND_WRITE  = 3'd6;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_PENDING   = 3'd1,
        ST_DONE_OK   = 3'd2,
        ST_DONE_ERR  = 3'd3,
        ST_CANCELLED = 3'd4
    } trk_state_t;

    typedef enum logic [1:0] {
        CL_NONE   = 2'd0,
        CL_ACK    = 2'd1,
        CL_ERR    = 2'd2,
        CL_CANCEL = 2'd3
    } close_t;

    typedef struct packed {
        logic ok;
        logic err;
        logic cxl;
        logic release_st;
    } done_t;

    // External transaction kinds during which a cancel is honoured
    function automatic logic cancel_kind(input logic [KIND_W-1:0] k);
        return (k == KIND_INVAL) || (k == KIND_UPDATE) ||
               (k == KIND_SNOOP) || (k == KIND_INTERV);
    endfunction

    function automatic done_t state_done(input trk_state_t s);
        done_t d;
        d.ok         = (s == ST_DONE_OK);
        d.err        = (s == ST_DONE_ERR);
        d.cxl        = (s == ST_CANCELLED);
        d.release_st = d.ok | d.err | d.cxl;
        return d;
    endfunction

endpackage

// File: rtl/irt_cancel_qual.sv
module irt_cancel_qual
    import irt_pkg::*;
(
    input  logic              ext_req_valid,
    input  logic [KIND_W-1:0] ext_req_kind,
    input  logic              cancel_in,
    output logic              cancel_ok
);
    always_comb begin
        cancel_ok = cancel_in & ext_req_valid & cancel_kind(ext_req_kind);
    end
endmodule

// File: rtl/irt_close_arb.sv
module irt_close_arb
    import irt_pkg::*;
(
    input  logic   active,
    input  logic   ack_in,
    input  logic   err_in,
    input  logic   cancel_ok,
    output close_t cause
);
    // Ranking: error, then acknowledge, then cancel
    always_comb begin
        cause = CL_NONE;
        if (active) begin
            if (err_in)         cause = CL_ERR;
            else if (ack_in)    cause = CL_ACK;
            else if (cancel_ok) cause = CL_CANCEL;
        end
    end
endmodule

// File: rtl/irt_line_reg.sv
module irt_line_reg #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [LINE_W-1:0] d,
    output logic [LINE_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/inv_req_tracker.sv
module inv_req_tracker
    import irt_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mp_enable,
    input  logic              req_valid,
    input  logic [LINE_W-1:0] req_addr,
    input  logic              ack_in,
    input  logic              err_in,
    input  logic              cancel_in,
    input  logic              ext_req_valid,
    input  logic [2:0]        ext_req_kind,
    output logic              req_ready,
    output logic              pending,
    output logic [LINE_W-1:0] line_addr,
    output logic              done_ok,
    output logic              bus_err,
    output logic              cancelled,
    output logic              store_release,
    output logic              proto_viol
);
    trk_state_t state_q, state_d;
    close_t     cause;
    done_t      done;
    logic       cancel_ok;
    logic       accept;
    logic       stray;
    logic       viol_q;

    irt_cancel_qual u_cancel (
        .ext_req_valid (ext_req_valid),
        .ext_req_kind  (ext_req_kind),
        .cancel_in     (cancel_in),
        .cancel_ok     (cancel_ok)
    );

    irt_close_arb u_arb (
        .active    (state_q == ST_PENDING),
        .ack_in    (ack_in),
        .err_in    (err_in),
        .cancel_ok (cancel_ok),
        .cause     (cause)
    );

    assign accept = (state_q == ST_IDLE) & req_valid & mp_enable;
    assign stray  = (state_q == ST_IDLE) & (ack_in | err_in);

    irt_line_reg #(.LINE_W(LINE_W)) u_line (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .d    (req_addr),
        .q    (line_addr)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept) state_d = ST_PENDING;
            ST_PENDING: begin
                unique case (cause)
                    CL_ERR:    state_d = ST_DONE_ERR;
                    CL_ACK:    state_d = ST_DONE_OK;
                    CL_CANCEL: state_d = ST_CANCELLED;
                    default:   state_d = ST_PENDING;
                endcase
            end
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (stray) viol_q <= 1'b1;
        end
    end

    always_comb begin
        done          = state_done(state_q);
        req_ready     = (state_q == ST_IDLE);
        pending       = (state_q == ST_PENDING);
        done_ok       = done.ok;
        bus_err       = done.err;
        cancelled     = done.cxl;
        store_release = done.release_st;
        proto_viol    = viol_q;
    end

endmodule

// File: rtl/inv_req_tracker_chk.sv
module inv_req_tracker_chk
    import irt_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              mp_enable,
    input logic              req_valid,
    input logic [LINE_W-1:0] req_addr,
    input logic              ack_in,
    input logic              err_in,
    input logic              cancel_in,
    input logic              ext_req_valid,
    input logic [2:0]        ext_req_kind,
    input logic              req_ready,
    input logic              pending,
    input logic [LINE_W-1:0] line_addr,
    input logic              done_ok,
    input logic              bus_err,
    input logic              cancelled,
    input logic              store_release,
    input logic              proto_viol
);
    p_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (req_ready && req_valid && mp_enable) |=> (pending && !req_ready && line_addr == $past(req_addr)));

    p_mp_off_r3: assert property (@(posedge clk) disable iff (rst)
        (req_ready && !mp_enable) |=> req_ready);

    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack_in && !err_in && !cancel_in) |=> (pending && $stable(line_addr)));

    p_ack_r5: assert property (@(posedge clk) disable iff (rst)
        (pending && ack_in && !err_in) |=> (done_ok && store_release));

    p_err_prio_r7: assert property (@(posedge clk) disable iff (rst)
        (pending && err_in) |=> (bus_err && !done_ok && $stable(line_addr)));

    p_cancel_kind_r8: assert property (@(posedge clk) disable iff (rst)
        (pending && !ack_in && !err_in && cancel_in && ext_req_valid && !cancel_kind(ext_req_kind)) |=> pending);

    p_stray_r10: assert property (@(posedge clk) disable iff (rst)
        (req_ready && (ack_in || err_in)) |=> (proto_viol && !store_release));

    p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        proto_viol |=> proto_viol);

    p_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done_ok, bus_err, cancelled}));

    p_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        store_release |=> (!store_release && req_ready));
endmodule

bind inv_req_tracker inv_req_tracker_chk #(.LINE_W(LINE_W)) u_chk (.*);

// File: tb/inv_req_tracker_tb.sv
module inv_req_tracker_tb;
    localparam int LINE_W = 26;
    localparam int NV = 14;

    // {ack, err, cancel, ext_valid, kind[2:0], expected[1:0]}
    // expected: 0 ok, 1 error, 2 cancelled, 3 still pending
    localparam logic [8:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,3'd0,2'd0},
        {1'b0,1'b1,1'b0,1'b0,3'd0,2'd1},
        {1'b1,1'b1,1'b0,1'b0,3'd0,2'd1},
        {1'b0,1'b0,1'b1,1'b1,3'd1,2'd2},
        {1'b0,1'b0,1'b1,1'b1,3'd2,2'd2},
        {1'b0,1'b0,1'b1,1'b1,3'd3,2'd2},
        {1'b0,1'b0,1'b1,1'b1,3'd4,2'd2},
        {1'b0,1'b0,1'b1,1'b0,3'd1,2'd3},
        {1'b0,1'b0,1'b1,1'b1,3'd5,2'd3},
        {1'b0,1'b0,1'b1,1'b1,3'd0,2'd3},
        {1'b1,1'b0,1'b1,1'b1,3'd1,2'd0},
        {1'b0,1'b1,1'b1,1'b1,3'd3,2'd1},
        {1'b1,1'b0,1'b0,1'b1,3'd5,2'd0},
        {1'b0,1'b1,1'b0,1'b1,3'd2,2'd1}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              mp_enable, req_valid, ack_in, err_in, cancel_in, ext_req_valid;
    logic [LINE_W-1:0] req_addr;
    logic [2:0]        ext_req_kind;
    logic              req_ready, pending, done_ok, bus_err, cancelled, store_release, proto_viol;
    logic [LINE_W-1:0] line_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    inv_req_tracker #(.LINE_W(LINE_W)) u_dut (
        .clk(clk), .rst(rst), .mp_enable(mp_enable), .req_valid(req_valid),
        .req_addr(req_addr), .ack_in(ack_in), .err_in(err_in), .cancel_in(cancel_in),
        .ext_req_valid(ext_req_valid), .ext_req_kind(ext_req_kind),
        .req_ready(req_ready), .pending(pending), .line_addr(line_addr),
        .done_ok(done_ok), .bus_err(bus_err), .cancelled(cancelled),
        .store_release(store_release), .proto_viol(proto_viol)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_in();
        req_valid = 0; ack_in = 0; err_in = 0; cancel_in = 0;
        ext_req_valid = 0; ext_req_kind = 3'd0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1; mp_enable = 1; req_addr = '0;
        clear_in();
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "ready", req_ready, 1);
        chk("R1", "pending", pending, 0);
        chk("R1", "pulses", {done_ok, bus_err, cancelled, store_release}, 0);
        chk("R1", "viol", proto_viol, 0);
        chk("R1", "line", line_addr, 0);

        // Table walk: R2, R5..R9
        for (int i = 0; i < NV; i++) begin
            logic [LINE_W-1:0] a;
            logic [8:0] v;
            v = VEC[i];
            a = LINE_W'(32'h100 + i * 37);
            req_valid = 1; req_addr = a;
            @(negedge clk);
            clear_in();
            chk("R2", "pending after accept", pending, 1);
            chk("R2", "line addr", line_addr, a);
            ack_in = v[8]; err_in = v[7]; cancel_in = v[6];
            ext_req_valid = v[5]; ext_req_kind = v[4:2];
            @(negedge clk);
            clear_in();
            case (v[1:0])
                2'd0: chk("R5", "ok pulses", {done_ok, bus_err, cancelled, store_release}, 4'b1001);
                2'd1: begin
                    chk("R7", "err pulses", {done_ok, bus_err, cancelled, store_release}, 4'b0101);
                    chk("R6", "err line", line_addr, a);
                end
                2'd2: chk("R8", "cancel pulses", {done_ok, bus_err, cancelled, store_release}, 4'b0011);
                default: begin
                    chk("R8", "ignored cancel", {pending, store_release}, 2'b10);
                    ack_in = 1;
                    @(negedge clk);
                    clear_in();
                    chk("R5", "late ack", {done_ok, store_release}, 2'b11);
                end
            endcase
            @(negedge clk);
            chk("R11", "idle after close", {req_ready, store_release}, 2'b10);
        end

        // R3: disabled configuration
        mp_enable = 0; req_valid = 1; req_addr = 'h3abc;
        @(negedge clk);
        clear_in();
        chk("R3", "ignored req", {req_ready, pending}, 2'b10);
        mp_enable = 1;

        // R4: request while pending refused
        req_valid = 1; req_addr = 'h111;
        @(negedge clk);
        req_addr = 'h222;
        @(negedge clk);
        chk("R4", "still pending", pending, 1);
        chk("R4", "addr unchanged", line_addr, 'h111);
        clear_in();
        @(negedge clk);
        chk("R4", "holds without close", pending, 1);
        ack_in = 1;
        @(negedge clk);
        clear_in();
        // R11: request during completion cycle refused
        req_valid = 1; req_addr = 'h333;
        chk("R11", "ready low in done", req_ready, 0);
        @(negedge clk);
        clear_in();
        chk("R11", "req refused in done", {req_ready, pending, line_addr == 'h111}, 3'b101);

        // R10: stray completion while idle
        ack_in = 1;
        @(negedge clk);
        clear_in();
        chk("R10", "stray ack", {req_ready, done_ok, store_release, proto_viol}, 4'b1001);
        err_in = 1;
        @(negedge clk);
        clear_in();
        chk("R10", "stray err", {req_ready, bus_err, proto_viol}, 3'b101);
        repeat (3) @(negedge clk);
        chk("R10", "sticky", proto_viol, 1);
        rst = 1;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R10", "cleared by reset", proto_viol, 0);

        finish_run();
    end
endmodule